// File: doc/BRIEF.md
# Virtual Event Injection Encoder

This block records an interrupt or exception into the event-injection word of a guest control block. It is used when an event must be delivered while the processor runs under a hypervisor. A one-cycle `start` presents the event: its vector, whether it came from a software interrupt instruction, an error code, and whether the processor is in real mode. The block also sees the injection word as it currently stands in the control block.

If an event is already pending in that word, the block writes nothing. Otherwise it builds a new injection word with the vector, an event type and a valid flag. When the processor is outside real mode and the vector is one that pushes an error code, it also sets an error-valid flag and writes the error code to a second word. Both write strobes come out in the cycle after `start`, together with a `done` pulse. The control block that receives the writes is outside this block.

Top module: `vevent_recorder`

## Requirements
- R1: If bit 31 (valid) of `cur_word` is set when `start` is sampled, neither `word_we` nor `err_we` is raised, and the stored words stay unchanged.
- R2: Bits 10:8 of the written injection word hold the event type: 4 when `soft_int` is set, 3 otherwise.
- R3: The written injection word carries the vector in bits 7:0 and bit 31 set. Every bit other than 7:0, 10:8, 11 and 31 is zero.
- R4: The vectors that carry an error code are 8, 10, 11, 12, 13, 14 and 17, whatever the event type. All other vectors never carry one.
- R5: Outside real mode, for an error-carrying vector, `err_we` rises with `err_wdata` equal to `err_code`, and bit 11 of the injection word is set. This happens in the same cycle as `word_we`, never without it.
- R6: With `real_mode` set, `err_we` stays low and bit 11 of the injection word is clear, even for an error-carrying vector.
- R7: `done` is high for exactly the cycle after each `start`. The write strobes appear only in that cycle.
- R8: During and right after reset, `word_we`, `err_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to record an event |
| vector | input | VEC_W (8) | Event vector number |
| soft_int | input | 1 | Event came from a software interrupt instruction |
| err_code | input | WORD_W (32) | Error code to attach |
| real_mode | input | 1 | Processor is in real mode |
| cur_word | input | WORD_W (32) | Injection word as currently stored |
| word_we | output | 1 | Write strobe for the injection word |
| word_wdata | output | WORD_W (32) | New injection word |
| err_we | output | 1 | Write strobe for the error-code word |
| err_wdata | output | WORD_W (32) | Error code to store |
| done | output | 1 | Pulse one cycle after `start` |

## Verification
The assertions assume that `cur_word`, `vector`, `soft_int`, `real_mode` and `err_code` are stable on the clock edge where `start` is sampled. They also assume that `cur_word` reflects any write the block issued before that edge. The bench drives every input on the falling edge and leaves an idle cycle between requests, so the stand-in store has taken the previous write before the next `start` reads it. Back-to-back starts on adjacent edges are never driven, because the second one would read a word the store has not yet updated.

// File: rtl/vinj_pkg.sv
package vinj_pkg;
   typedef enum logic [2:0] {
      EV_EXCEPTION = 3'd3,
      EV_SOFTINT   = 3'd4
   } ev_type_e;
endpackage

// File: rtl/vinj_errvec_lookup.sv
module vinj_errvec_lookup #(
   parameter int VEC_W = 8
) (
   input  logic [VEC_W-1:0] vector,
   output logic             has_err
);
   always_comb begin
      case (vector)
         VEC_W'(8), VEC_W'(10), VEC_W'(11), VEC_W'(12),
         VEC_W'(13), VEC_W'(14), VEC_W'(17): has_err = 1'b1;
         default:                            has_err = 1'b0;
      endcase
   end
endmodule

// File: rtl/vinj_word_build.sv
module vinj_word_build
   import vinj_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int WORD_W    = 32,
   parameter int TYPE_LSB  = 8,
   parameter int ERRV_BIT  = 11,
   parameter int VALID_BIT = 31
) (
   input  logic [VEC_W-1:0]  vector,
   input  logic              soft_int,
   input  logic              attach_err,
   output logic [WORD_W-1:0] word
);
   localparam int TYPE_W = $bits(ev_type_e);

   ev_type_e ev_type;
   assign ev_type = soft_int ? EV_SOFTINT : EV_EXCEPTION;

   always_comb begin
      word = '0;
      word[VEC_W-1:0]                = vector;
      word[TYPE_LSB +: TYPE_W]       = ev_type;
      word[ERRV_BIT]                 = attach_err;
      word[VALID_BIT]                = 1'b1;
   end
endmodule

// File: rtl/vevent_recorder.sv
module vevent_recorder #(
   parameter int VEC_W     = 8,
   parameter int WORD_W    = 32,
   parameter int TYPE_LSB  = 8,
   parameter int ERRV_BIT  = 11,
   parameter int VALID_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VEC_W-1:0]  vector,
   input  logic              soft_int,
   input  logic [WORD_W-1:0] err_code,
   input  logic              real_mode,
   input  logic [WORD_W-1:0] cur_word,
   output logic              word_we,
   output logic [WORD_W-1:0] word_wdata,
   output logic              err_we,
   output logic [WORD_W-1:0] err_wdata,
   output logic              done
);
   localparam int TYPE_W = $bits(vinj_pkg::ev_type_e);

   // elaboration-time layout checks
   if (VEC_W > TYPE_LSB) begin : g_bad_vec
      $error("vector field overlaps type field");
   end
   if (TYPE_LSB + TYPE_W > ERRV_BIT) begin : g_bad_type
      $error("type field overlaps error-valid bit");
   end
   if (ERRV_BIT >= VALID_BIT || VALID_BIT >= WORD_W) begin : g_bad_flags
      $error("flag bits out of order or outside the word");
   end

   logic              pending;
   logic              vec_has_err;
   logic              attach_err;
   logic              do_write;
   logic [WORD_W-1:0] new_word;

   assign pending    = cur_word[VALID_BIT];
   assign attach_err = vec_has_err & ~real_mode;
   assign do_write   = start & ~pending;

   vinj_errvec_lookup #(.VEC_W(VEC_W)) u_lookup (
      .vector  (vector),
      .has_err (vec_has_err)
   );

   vinj_word_build #(
      .VEC_W(VEC_W), .WORD_W(WORD_W), .TYPE_LSB(TYPE_LSB),
      .ERRV_BIT(ERRV_BIT), .VALID_BIT(VALID_BIT)
   ) u_build (
      .vector     (vector),
      .soft_int   (soft_int),
      .attach_err (attach_err),
      .word       (new_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         word_we    <= 1'b0;
         err_we     <= 1'b0;
         word_wdata <= '0;
         err_wdata  <= '0;
      end else begin
         done    <= start;
         word_we <= do_write;
         err_we  <= do_write & attach_err;
         if (do_write) begin
            word_wdata <= new_word;
         end
         if (do_write & attach_err) begin
            err_wdata <= err_code;
         end
      end
   end
endmodule

// File: rtl/vevent_recorder_chk.sv
module vevent_recorder_chk #(
   parameter int WORD_W    = 32,
   parameter int ERRV_BIT  = 11,
   parameter int VALID_BIT = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              real_mode,
   input logic [WORD_W-1:0] err_code,
   input logic [WORD_W-1:0] cur_word,
   input logic              word_we,
   input logic [WORD_W-1:0] word_wdata,
   input logic              err_we,
   input logic [WORD_W-1:0] err_wdata,
   input logic              done
);
   // R1
   pending_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && cur_word[VALID_BIT] |=> !word_we && !err_we);
   // R3
   valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_we |-> word_wdata[VALID_BIT]);
   // R5
   err_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_we |-> word_we && word_wdata[ERRV_BIT]);
   // R5
   errv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_we |-> word_wdata[ERRV_BIT] == err_we);
   // R5
   err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_we |-> err_wdata == $past(err_code));
   // R6
   real_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && real_mode |=> !err_we);
   // R7
   done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   // R7
   done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));
   // R7
   write_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_we |-> done);
endmodule

bind vevent_recorder vevent_recorder_chk #(
   .WORD_W(WORD_W), .ERRV_BIT(ERRV_BIT), .VALID_BIT(VALID_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .real_mode(real_mode),
   .err_code(err_code), .cur_word(cur_word), .word_we(word_we),
   .word_wdata(word_wdata), .err_we(err_we), .err_wdata(err_wdata),
   .done(done)
);

// File: tb/test_vevent_recorder.sv
module test_vevent_recorder;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;
   localparam int WDOG = 100000;
   localparam logic [31:0] PEND_WORD = 32'h8000_0321;

   // fields: [44] pending, [43] soft, [42] real, [41:34] vector,
   //         [33] exp word_we, [32] exp err_we, [31:0] exp word
   localparam logic [44:0] TBL [NVEC] = '{
      {1'b0, 1'b0, 1'b0, 8'h0E, 1'b1, 1'b1, 32'h8000_0B0E},
      {1'b0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0, 32'h8000_0480},
      {1'b0, 1'b0, 1'b0, 8'h06, 1'b1, 1'b0, 32'h8000_0306},
      {1'b0, 1'b0, 1'b1, 8'h08, 1'b1, 1'b0, 32'h8000_0308},
      {1'b0, 1'b0, 1'b0, 8'h11, 1'b1, 1'b1, 32'h8000_0B11},
      {1'b1, 1'b0, 1'b0, 8'h0D, 1'b0, 1'b0, 32'h0000_0000},
      {1'b0, 1'b0, 1'b0, 8'h0A, 1'b1, 1'b1, 32'h8000_0B0A},
      {1'b0, 1'b0, 1'b0, 8'h09, 1'b1, 1'b0, 32'h8000_0309},
      {1'b0, 1'b1, 1'b0, 8'h0D, 1'b1, 1'b1, 32'h8000_0C0D},
      {1'b0, 1'b1, 1'b1, 8'h0E, 1'b1, 1'b0, 32'h8000_040E}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  vector = '0;
   logic        soft_int = 1'b0;
   logic [31:0] err_code = '0;
   logic        real_mode = 1'b0;
   logic        word_we, err_we, done;
   logic [31:0] word_wdata, err_wdata;
   logic        host_we = 1'b0;
   logic [31:0] host_val = '0;
   logic [31:0] mdl_word, mdl_err;
   int          errors = 0;
   int          checks = 0;
   int          cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // two-register stand-in for the control block
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdl_word <= '0;
         mdl_err  <= '0;
      end else if (host_we) begin
         mdl_word <= host_val;
         mdl_err  <= '0;
      end else begin
         if (word_we) mdl_word <= word_wdata;
         if (err_we)  mdl_err  <= err_wdata;
      end
   end

   vevent_recorder i_vevent_recorder (
      .clk(clk), .rst_n(rst_n), .start(start), .vector(vector),
      .soft_int(soft_int), .err_code(err_code), .real_mode(real_mode),
      .cur_word(mdl_word), .word_we(word_we), .word_wdata(word_wdata),
      .err_we(err_we), .err_wdata(err_wdata), .done(done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic preload(input logic [31:0] val);
      host_we  = 1'b1;
      host_val = val;
      @(negedge clk);
      host_we  = 1'b0;
   endtask

   task automatic fire(input logic [7:0] v, input logic s, input logic r, input logic [31:0] e);
      vector = v; soft_int = s; real_mode = r; err_code = e;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8 outputs low in reset
      chk("R8 word_we", {31'd0, word_we}, 32'd0);
      chk("R8 err_we",  {31'd0, err_we},  32'd0);
      chk("R8 done",    {31'd0, done},    32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 done after reset", {31'd0, done}, 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         logic [44:0] t;
         logic [31:0] ecode;
         t = TBL[i];
         ecode = 32'hC0DE_0000 + 32'(i);
         preload(t[44] ? PEND_WORD : 32'd0);
         fire(t[41:34], t[43], t[42], ecode);
         // R7 writes and done in the cycle after start; R1 no write when pending
         chk("R7 done", {31'd0, done}, 32'd1);
         chk("R1/R5 word_we", {31'd0, word_we}, {31'd0, t[33]});
         chk("R4/R5/R6 err_we", {31'd0, err_we}, {31'd0, t[32]});
         if (t[33]) chk("R2/R3 word", word_wdata, t[31:0]);
         if (t[32]) chk("R5 err data", err_wdata, ecode);
         @(negedge clk);
         chk("R7 done one cycle", {31'd0, done}, 32'd0);
         chk("R7 no late write", {30'd0, word_we, err_we}, 32'd0);
         chk("R1/R3 stored word", mdl_word, t[33] ? t[31:0] : (t[44] ? PEND_WORD : 32'd0));
         chk("R1/R5 stored err", mdl_err, t[32] ? ecode : 32'd0);
      end

      // R1 second request after an idle cycle sees the first event pending
      preload(32'd0);
      fire(8'h0C, 1'b0, 1'b0, 32'h0000_1234);
      @(negedge clk);
      fire(8'h05, 1'b1, 1'b0, 32'h0000_5678);
      chk("R1 second start no word_we", {31'd0, word_we}, 32'd0);
      chk("R1 second start done", {31'd0, done}, 32'd1);
      @(negedge clk);
      chk("R1 stored word kept", mdl_word, 32'h8000_0B0C);
      chk("R1 stored err kept", mdl_err, 32'h0000_1234);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule